// File: doc/BRIEF.md
# Per-Core Work Tag State Tracker

This block keeps the scheduling tag that one processing core currently holds in a work-scheduling system. It records a 2-bit tag type and a tag value. Requests arrive on a valid/ready port. Each request carries an operation code, a target tag type and a tag value. Four operations exist: a tag switch, a delivery of new work, a deschedule, and a null-switch load. The tracker decides whether a request is legal given the current tag type. A legal request updates the stored state. An illegal one leaves the state untouched and raises an error pulse for one cycle. The handshake completes in both cases.

The tag type is a four-state machine. The states are ORDERED (ordering kept), ATOMIC (ordering kept and the tag held exclusively by this core), NULL, and NULLNULL (no scheduler space reserved). The transitions are named as follows:
- SWITCH_FREE: ORDERED and ATOMIC go to ORDERED, ATOMIC or NULL.
- SWITCH_FROM_NULL: NULL goes to ORDERED or ATOMIC.
- WORK_LOAD: any state goes to ORDERED, ATOMIC or NULL.
- DESCHEDULE: any state goes to NULLNULL.
- NULL_LOAD: any state other than NULL goes to NULL.

The forbidden moves are:
- a switch from NULL to NULL;
- any switch into NULLNULL;
- any switch out of NULLNULL.

The machine leaves reset in NULLNULL. The `atomic_held` output shows whether the core holds an exclusive tag. Outside logic that hands atomic ownership between cores watches this output.

Top module: `work_tag_tracker`

## Requirements
- R1: After reset, `cur_type` is NULLNULL (code 3), `cur_tag` is 0, `err_pulse` and `atomic_held` are 0, and `req_ready` is 1 from the first clock edge after reset is released.
- R2: A tag switch (`req_op` = 0) while the state is NULLNULL is rejected, and the state stays NULLNULL.
- R3: A null-switch load (`req_op` = 3) in NULLNULL moves the type to NULL (code 2) and keeps `cur_tag`.
- R4: A tag switch from NULL with target NULL is rejected.
- R5: A tag switch with target NULLNULL is rejected from every state.
- R6: A new work delivery (`req_op` = 1) loads `req_type` and `req_tag` from any state. If `req_type` is NULLNULL, the delivery is rejected instead.
- R7: A tag switch from ORDERED (0), ATOMIC (1) or NULL to ORDERED or ATOMIC, and from ORDERED or ATOMIC to NULL, is accepted and loads both `req_type` and `req_tag`.
- R8: A deschedule (`req_op` = 2) from any state moves the type to NULLNULL and keeps `cur_tag`.
- R9: `atomic_held` is 1 exactly while the type is ATOMIC.
- R10: A rejected request still completes its handshake (`req_ready` stays 1). It raises `err_pulse` for exactly the one cycle after the accepting edge. It changes neither `cur_type` nor `cur_tag`.
- R11: A null-switch load from ORDERED or ATOMIC moves the type to NULL and keeps the tag. A null-switch load from NULL is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Tracker can take a request |
| req_op | input | 2 | 0 switch, 1 new work, 2 deschedule, 3 null-switch load |
| req_type | input | 2 | Target tag type: 0 ordered, 1 atomic, 2 null, 3 null-null |
| req_tag | input | TAG_W | Tag value supplied with a switch or new work |
| cur_type | output | 2 | Current tag type |
| cur_tag | output | TAG_W | Current tag value |
| atomic_held | output | 1 | Core holds an exclusive tag |
| err_pulse | output | 1 | One-cycle flag for a rejected request |

## Verification
The embedded assertions check these properties on every cycle:
- a rejected request never disturbs the stored state, and an error only follows an accepted request;
- no switch from NULLNULL ever leaves it, and no request other than a deschedule enters it from another state;
- a deschedule always lands in NULLNULL with the tag kept;
- `atomic_held` only rises right after a request.

The directed scenarios are needed for the parts the assertions do not cover:
- that each legal transition loads the exact type and tag supplied;
- that a new work delivery is accepted from every state;
- that a null-switch load from NULL is refused;
- that the error lasts exactly one cycle when a legal request follows.

// File: rtl/wtt_pkg.sv
package wtt_pkg;

    typedef enum logic [1:0] {
        TT_ORDERED  = 2'd0,
        TT_ATOMIC   = 2'd1,
        TT_NULL     = 2'd2,
        TT_NULLNULL = 2'd3
    } tag_type_e;

    typedef enum logic [1:0] {
        OP_SWITCH   = 2'd0,
        OP_NEWWORK  = 2'd1,
        OP_DESCHED  = 2'd2,
        OP_NULLLOAD = 2'd3
    } req_op_e;

    typedef struct packed {
        logic      legal;
        tag_type_e nxt_type;
        logic      load_tag;
    } verdict_t;

endpackage

// File: rtl/wtt_rules.sv
module wtt_rules
    import wtt_pkg::*;
(
    input  tag_type_e cur_type,
    input  req_op_e   op,
    input  tag_type_e tgt_type,
    output verdict_t  verdict
);

    logic      legal;
    tag_type_e nxt;
    logic      ld;

    always_comb begin
        legal = 1'b0;
        nxt   = cur_type;
        ld    = 1'b0;
        unique case (op)
            OP_SWITCH: begin
                unique case (cur_type)
                    TT_NULLNULL: legal = 1'b0;
                    TT_NULL:     legal = (tgt_type == TT_ORDERED) || (tgt_type == TT_ATOMIC);
                    TT_ORDERED,
                    TT_ATOMIC:   legal = (tgt_type != TT_NULLNULL);
                endcase
                if (legal) begin
                    nxt = tgt_type;
                    ld  = 1'b1;
                end
            end
            OP_NEWWORK: begin
                legal = (tgt_type != TT_NULLNULL);
                if (legal) begin
                    nxt = tgt_type;
                    ld  = 1'b1;
                end
            end
            OP_DESCHED: begin
                legal = 1'b1;
                nxt   = TT_NULLNULL;
            end
            OP_NULLLOAD: begin
                legal = (cur_type != TT_NULL);
                if (legal) begin
                    nxt = TT_NULL;
                end
            end
        endcase
    end

    assign verdict = '{legal: legal, nxt_type: nxt, load_tag: ld};

endmodule

// File: rtl/wtt_state.sv
module wtt_state
    import wtt_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  verdict_t         verdict,
    input  logic [TAG_W-1:0] req_tag,
    output tag_type_e        cur_type,
    output logic [TAG_W-1:0] cur_tag,
    output logic             err_pulse
);

    tag_type_e        type_q;
    logic [TAG_W-1:0] tag_q;
    logic             err_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= TT_NULLNULL;
            tag_q  <= '0;
        end else if (accept && verdict.legal) begin
            type_q <= verdict.nxt_type;
            if (verdict.load_tag) begin
                tag_q <= req_tag;
            end
        end
    end

    // error flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= accept && !verdict.legal;
        end
    end

    always_comb begin
        cur_type  = type_q;
        cur_tag   = tag_q;
        err_pulse = err_q;
    end

    // R10
    err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($stable(cur_type) && $stable(cur_tag)));

    // R10
    err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(accept));

endmodule

// File: rtl/work_tag_tracker.sv
module work_tag_tracker
    import wtt_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [1:0]       req_type,
    input  logic [TAG_W-1:0] req_tag,
    output logic [1:0]       cur_type,
    output logic [TAG_W-1:0] cur_tag,
    output logic             atomic_held,
    output logic             err_pulse
);

    logic      ready_q;
    logic      accept;
    tag_type_e state_type;
    verdict_t  verdict;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign accept = req_valid && ready_q;

    wtt_rules u_rules (
        .cur_type (state_type),
        .op       (req_op_e'(req_op)),
        .tgt_type (tag_type_e'(req_type)),
        .verdict  (verdict)
    );

    wtt_state #(.TAG_W(TAG_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .verdict   (verdict),
        .req_tag   (req_tag),
        .cur_type  (state_type),
        .cur_tag   (cur_tag),
        .err_pulse (err_pulse)
    );

    // output process
    always_comb begin
        req_ready   = ready_q;
        cur_type    = state_type;
        atomic_held = (state_type == TT_ATOMIC);
    end

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    // R2
    stay_nullnull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_type == 2'd3 && req_op == 2'd0) |=> (cur_type == 2'd3));

    // R5
    no_enter_nullnull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_type != 2'd3 && req_op != 2'd2) |=> (cur_type != 2'd3));

    // R3
    nullload_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_type == 2'd3 && req_op == 2'd3) |=> (cur_type == 2'd2));

    // R8
    desched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == 2'd2) |=> (cur_type == 2'd3 && $stable(cur_tag)));

    // R9
    atomic_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(atomic_held) |-> $past(accept));

endmodule

// File: tb/work_tag_tracker_bench.sv
module work_tag_tracker_bench;

    localparam int TAG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = 2'd0;
    logic [1:0]       req_type = 2'd0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [1:0]       cur_type;
    logic [TAG_W-1:0] cur_tag;
    logic             atomic_held;
    logic             err_pulse;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    work_tag_tracker #(.TAG_W(TAG_W)) u_work_tag_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_type    (req_type),
        .req_tag     (req_tag),
        .cur_type    (cur_type),
        .cur_tag     (cur_tag),
        .atomic_held (atomic_held),
        .err_pulse   (err_pulse)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // one request, returns at the negedge after the accepting edge
    task automatic send(input logic [1:0] op, input logic [1:0] ty, input logic [TAG_W-1:0] tg);
        @(negedge clk);
        req_op    = op;
        req_type  = ty;
        req_tag   = tg;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_st(input string rq, input logic [1:0] ty, input logic [TAG_W-1:0] tg,
                             input logic er);
        chk(rq, "type", cur_type, ty);
        chk(rq, "tag", cur_tag, tg);
        chk(rq, "err", err_pulse, er);
        chk(rq, "atomic_held R9", atomic_held, ty == 2'd1);
        chk(rq, "ready", req_ready, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "type in reset", cur_type, 3);
        chk("R1", "err in reset", err_pulse, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        expect_st("R1", 2'd3, '0, 1'b0);
    endtask

    task automatic t_nullnull_guard();
        send(2'd0, 2'd0, 32'h1111_0000);
        expect_st("R2", 2'd3, '0, 1'b1);
        send(2'd1, 2'd3, 32'h2222_0000);
        expect_st("R6", 2'd3, '0, 1'b1);
        send(2'd3, 2'd0, 32'h3333_0000);
        expect_st("R3", 2'd2, '0, 1'b0);
    endtask

    task automatic t_null_rules();
        send(2'd0, 2'd2, 32'h4444_0000);
        expect_st("R4", 2'd2, '0, 1'b1);
        send(2'd3, 2'd0, 32'h0);
        expect_st("R11", 2'd2, '0, 1'b1);
        send(2'd0, 2'd3, 32'h5555_0000);
        expect_st("R5", 2'd2, '0, 1'b1);
        send(2'd0, 2'd1, 32'hA0A0_0001);
        expect_st("R7", 2'd1, 32'hA0A0_0001, 1'b0);
    endtask

    task automatic t_switch_chain();
        send(2'd0, 2'd0, 32'hB0B0_0002);
        expect_st("R7", 2'd0, 32'hB0B0_0002, 1'b0);
        send(2'd0, 2'd3, 32'hDEAD_0000);
        expect_st("R5", 2'd0, 32'hB0B0_0002, 1'b1);
        send(2'd0, 2'd1, 32'hC0C0_0003);
        expect_st("R7", 2'd1, 32'hC0C0_0003, 1'b0);
        send(2'd0, 2'd3, 32'hDEAD_0001);
        expect_st("R5", 2'd1, 32'hC0C0_0003, 1'b1);
        send(2'd0, 2'd2, 32'hD0D0_0004);
        expect_st("R7", 2'd2, 32'hD0D0_0004, 1'b0);
    endtask

    task automatic t_error_one_cycle();
        send(2'd0, 2'd2, 32'hEEEE_0000);
        expect_st("R10", 2'd2, 32'hD0D0_0004, 1'b1);
        @(negedge clk);
        chk("R10", "err cleared", err_pulse, 0);
        chk("R10", "ready kept", req_ready, 1);
        send(2'd0, 2'd2, 32'hEEEE_0001);
        send(2'd0, 2'd0, 32'h1234_5678);
        expect_st("R10", 2'd0, 32'h1234_5678, 1'b0);
    endtask

    task automatic t_desched_and_work();
        send(2'd2, 2'd0, 32'hFFFF_FFFF);
        expect_st("R8", 2'd3, 32'h1234_5678, 1'b0);
        send(2'd1, 2'd1, 32'hE0E0_0005);
        expect_st("R6", 2'd1, 32'hE0E0_0005, 1'b0);
        send(2'd2, 2'd2, 32'h0);
        expect_st("R8", 2'd3, 32'hE0E0_0005, 1'b0);
        send(2'd1, 2'd2, 32'hF0F0_0006);
        expect_st("R6", 2'd2, 32'hF0F0_0006, 1'b0);
        send(2'd1, 2'd0, 32'h0101_0007);
        expect_st("R6", 2'd0, 32'h0101_0007, 1'b0);
        send(2'd1, 2'd1, 32'h0202_0008);
        expect_st("R6", 2'd1, 32'h0202_0008, 1'b0);
        send(2'd1, 2'd3, 32'h0303_0009);
        expect_st("R6", 2'd1, 32'h0202_0008, 1'b1);
    endtask

    task automatic t_nullload_paths();
        send(2'd3, 2'd0, 32'h0);
        expect_st("R11", 2'd2, 32'h0202_0008, 1'b0);
        send(2'd1, 2'd0, 32'h0404_000A);
        send(2'd3, 2'd1, 32'h0);
        expect_st("R11", 2'd2, 32'h0404_000A, 1'b0);
        send(2'd2, 2'd0, 32'h0);
        expect_st("R8", 2'd3, 32'h0404_000A, 1'b0);
    endtask

    initial begin
        t_reset();
        t_nullnull_guard();
        t_null_rules();
        t_switch_chain();
        t_error_one_cycle();
        t_desched_and_work();
        t_nullload_paths();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule